// File: doc/BRIEF.md
# Shader Condition Code Unit

This block keeps the two condition flags of a vector shader core and answers branch questions about them. A compare strobe carries two four-component single-precision operands and a separate 3-bit comparison code for each of the first two lanes. On the clock edge where the strobe is high, the X-lane result is stored in flag X and the Y-lane result in flag Y. The other components of the operands play no part. The flags change only on a strobe, so they persist from one program run to the next.

Two combinational query ports sit next to the flags. The condition port takes a reference bit per flag and a 2-bit combine mode, and returns one taken bit. A flag passes its test when it equals its reference bit. The uniform port picks one bit from a vector of boolean uniforms and reports whether that bit is set. An invert input flips the answer, for jumps that are taken on a clear uniform.

Top module: `shader_cond_unit`

## Requirements
- R1: After a synchronous active-low reset, both flags read 0.
- R2: On a cycle with `cmp_valid` high, flag X takes the result of `cmp_op_x` applied to bits [31:0] of A and B. Flag Y takes the result of `cmp_op_y` applied to bits [63:32]. Both appear on the flag outputs from the next cycle. The op codes are 0 equal, 1 not-equal, 2 A<B, 3 A<=B, 4 A>B and 5 A>=B.
- R3: When either operand of a lane is NaN, codes 0, 2, 3, 4 and 5 yield 0 and code 1 yields 1.
- R4: Comparison follows signed real order. +0 and -0 compare equal, and the infinities order below and above every finite value.
- R5: Op codes 6 and 7 yield 0.
- R6: With `cmp_valid` low the flags hold their values, whatever the operands and op codes do. Components above bit 63 never affect a flag.
- R7: `cond_taken` is combinational. Each flag passes when it equals its reference bit. The modes are 0 = either test passes, 1 = both pass, 2 = X test alone, 3 = Y test alone.
- R8: `bool_taken` is bit `bool_sel` of `bool_vec`, inverted when `bool_invert` is 1. A select beyond the vector gives 0 before inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 1 | Compare strobe |
| cmp_src_a | input | 128 | Operand A, component 0 (X) in the low 32 bits |
| cmp_src_b | input | 128 | Operand B, same layout |
| cmp_op_x | input | 3 | Comparison code for the X lane |
| cmp_op_y | input | 3 | Comparison code for the Y lane |
| flag_x | output | 1 | Stored X-lane flag |
| flag_y | output | 1 | Stored Y-lane flag |
| cond_ref_x | input | 1 | Reference bit for flag X |
| cond_ref_y | input | 1 | Reference bit for flag Y |
| cond_mode | input | 2 | Combine mode |
| cond_taken | output | 1 | Evaluated condition |
| bool_vec | input | 16 | Boolean uniforms |
| bool_sel | input | 4 | Uniform index |
| bool_invert | input | 1 | Invert the uniform result |
| bool_taken | output | 1 | Uniform condition |

## Verification
The hardest situations are the unordered ones: a NaN on one or both sides under each comparison code, including the swapped-operand greater-than forms. Signed zeros and infinities are also hard to reach, because only specific bit patterns produce them. The stimulus builds these operands directly as bit patterns and sets different codes on the X and Y lanes in the same strobe. This way one strobe shows both the ordered and the unordered rule. Flag persistence is checked by changing the operands, the codes and the Z/W components while the strobe stays low.

// File: rtl/scc_pkg.sv
// Shared encodings for the shader condition code unit.
// Assumes a 3-bit comparison code and a 2-bit combine mode.
package scc_pkg;

    typedef enum logic [2:0] {
        CMP_EQ = 3'd0,
        CMP_NE = 3'd1,
        CMP_LT = 3'd2,
        CMP_LE = 3'd3,
        CMP_GT = 3'd4,
        CMP_GE = 3'd5
    } cmp_op_e;

    typedef enum logic [1:0] {
        MODE_ANY   = 2'd0,
        MODE_BOTH  = 2'd1,
        MODE_XONLY = 2'd2,
        MODE_YONLY = 2'd3
    } comb_mode_e;

endpackage

// File: rtl/fp_lane_cmp.sv
// One-lane float comparator.
// It maps each operand to an unsigned order key: zeros collapse to one key,
// negatives are bit-inverted. The ordered relations then become integer
// compares, and NaN operands are folded in separately.
// Assumes IEEE-style layout: sign, EXP_W exponent bits, MAN_W fraction bits.
module fp_lane_cmp #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int FP_W = 1 + EXP_W + MAN_W
) (
    input  logic [FP_W-1:0] op_a,
    input  logic [FP_W-1:0] op_b,
    input  logic [2:0]      op_code,
    output logic            hit
);
    import scc_pkg::*;

    logic            nan_a, nan_b, any_nan;
    logic [FP_W-1:0] key_a, key_b;
    logic            a_lt_b, b_lt_a, a_eq_b;

    // Detect NaN: all-ones exponent with a nonzero fraction.
    always_comb begin
        nan_a   = (&op_a[FP_W-2 -: EXP_W]) && (op_a[MAN_W-1:0] != '0);
        nan_b   = (&op_b[FP_W-2 -: EXP_W]) && (op_b[MAN_W-1:0] != '0);
        any_nan = nan_a | nan_b;
    end

    // Build order-preserving keys; both signed zeros share one key.
    always_comb begin
        if (op_a[FP_W-2:0] == '0)   key_a = {1'b1, {(FP_W-1){1'b0}}};
        else if (op_a[FP_W-1])      key_a = ~op_a;
        else                        key_a = {1'b1, op_a[FP_W-2:0]};
        if (op_b[FP_W-2:0] == '0)   key_b = {1'b1, {(FP_W-1){1'b0}}};
        else if (op_b[FP_W-1])      key_b = ~op_b;
        else                        key_b = {1'b1, op_b[FP_W-2:0]};
    end

    // Raw relations on the keys.
    always_comb begin
        a_lt_b = key_a < key_b;
        b_lt_a = key_b < key_a;
        a_eq_b = key_a == key_b;
    end

    // Select the relation; greater forms use swapped less-than operands.
    always_comb begin
        case (op_code)
            CMP_EQ:  hit = !any_nan && a_eq_b;
            CMP_NE:  hit = any_nan || !a_eq_b;
            CMP_LT:  hit = !any_nan && a_lt_b;
            CMP_LE:  hit = !any_nan && (a_lt_b || a_eq_b);
            CMP_GT:  hit = !any_nan && b_lt_a;
            CMP_GE:  hit = !any_nan && (b_lt_a || a_eq_b);
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cond_combine.sv
// Branch condition evaluator.
// Each flag passes when it equals its reference bit. The two pass bits are
// then merged as the mode asks. Purely combinational.
module cond_combine (
    input  logic       flag_x,
    input  logic       flag_y,
    input  logic       ref_x,
    input  logic       ref_y,
    input  logic [1:0] mode,
    output logic       taken
);
    import scc_pkg::*;

    logic pass_x, pass_y;

    // Equality test of each flag against its reference.
    always_comb begin
        pass_x = flag_x ~^ ref_x;
        pass_y = flag_y ~^ ref_y;
    end

    // Merge the per-flag tests.
    always_comb begin
        case (mode)
            MODE_ANY:   taken = pass_x | pass_y;
            MODE_BOTH:  taken = pass_x & pass_y;
            MODE_XONLY: taken = pass_x;
            default:    taken = pass_y;
        endcase
    end

endmodule

// File: rtl/bool_uniform_test.sv
// Boolean uniform selector with optional inversion.
// An index beyond the vector selects a constant 0 before the inversion.
module bool_uniform_test #(
    parameter int NUM_BOOL = 16,
    localparam int SEL_W = (NUM_BOOL > 1) ? $clog2(NUM_BOOL) : 1
) (
    input  logic [NUM_BOOL-1:0] bools,
    input  logic [SEL_W-1:0]    sel,
    input  logic                invert,
    output logic                taken
);
    logic picked;

    // Pick the addressed uniform, guarding the out-of-range index.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NUM_BOOL; i++) begin
            if (sel == SEL_W'(i)) picked = bools[i];
        end
    end

    // Apply the inversion request.
    always_comb taken = picked ^ invert;

endmodule

// File: rtl/shader_cond_unit.sv
// Shader condition code unit, top level.
// It holds two flags written by a compare strobe; lane g of the operands
// feeds flag g. It also exposes a combinational condition evaluator and a
// boolean uniform test.
// Assumes LANES >= 2; components above lane 1 are not used.
module shader_cond_unit #(
    parameter int EXP_W    = 8,
    parameter int MAN_W    = 23,
    parameter int LANES    = 4,
    parameter int NUM_BOOL = 16,
    localparam int FP_W    = 1 + EXP_W + MAN_W,
    localparam int VEC_W   = LANES * FP_W,
    localparam int FLAG_N  = 2,
    localparam int SEL_W   = (NUM_BOOL > 1) ? $clog2(NUM_BOOL) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmp_valid,
    input  logic [VEC_W-1:0]    cmp_src_a,
    input  logic [VEC_W-1:0]    cmp_src_b,
    input  logic [2:0]          cmp_op_x,
    input  logic [2:0]          cmp_op_y,
    output logic                flag_x,
    output logic                flag_y,
    input  logic                cond_ref_x,
    input  logic                cond_ref_y,
    input  logic [1:0]          cond_mode,
    output logic                cond_taken,
    input  logic [NUM_BOOL-1:0] bool_vec,
    input  logic [SEL_W-1:0]    bool_sel,
    input  logic                bool_invert,
    output logic                bool_taken
);
    import scc_pkg::*;

    logic [FLAG_N-1:0] lane_hit;
    logic [FLAG_N-1:0] flag_q;
    logic [2:0]        lane_op [FLAG_N];

    // Route each lane's comparison code.
    always_comb begin
        lane_op[0] = cmp_op_x;
        lane_op[1] = cmp_op_y;
    end

    // One comparator per flag lane.
    for (genvar g = 0; g < FLAG_N; g++) begin : g_lane
        fp_lane_cmp #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cmp (
            .op_a    (cmp_src_a[g*FP_W +: FP_W]),
            .op_b    (cmp_src_b[g*FP_W +: FP_W]),
            .op_code (lane_op[g]),
            .hit     (lane_hit[g])
        );
    end

    // Upper components take no part in the flags.
    if (LANES > FLAG_N) begin : g_upper
        logic unused_upper;
        assign unused_upper = ^{cmp_src_a[VEC_W-1:FLAG_N*FP_W],
                                cmp_src_b[VEC_W-1:FLAG_N*FP_W]};
    end

    // Flag storage: load on strobe, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag_q <= '0;
        else if (cmp_valid)  flag_q <= lane_hit;
    end

    assign flag_x = flag_q[0];
    assign flag_y = flag_q[1];

    cond_combine u_comb (
        .flag_x (flag_q[0]),
        .flag_y (flag_q[1]),
        .ref_x  (cond_ref_x),
        .ref_y  (cond_ref_y),
        .mode   (cond_mode),
        .taken  (cond_taken)
    );

    bool_uniform_test #(.NUM_BOOL(NUM_BOOL)) u_bool (
        .bools  (bool_vec),
        .sel    (bool_sel),
        .invert (bool_invert),
        .taken  (bool_taken)
    );

    // Independent NaN view of the X lane for the unordered check.
    logic x_has_nan;
    always_comb begin
        x_has_nan = ((&cmp_src_a[FP_W-2 -: EXP_W]) && (cmp_src_a[MAN_W-1:0] != '0)) ||
                    ((&cmp_src_b[FP_W-2 -: EXP_W]) && (cmp_src_b[MAN_W-1:0] != '0));
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmp_valid |=> $stable(flag_q)); // R6
    AST_X_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> flag_x == $past(lane_hit[0])); // R2
    AST_Y_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_valid |=> flag_y == $past(lane_hit[1])); // R2
    AST_NAN_UNORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && x_has_nan && cmp_op_x != CMP_NE) |=> !flag_x); // R3
    AST_BOTH_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_mode == MODE_BOTH && cond_taken) |-> (flag_x == cond_ref_x && flag_y == cond_ref_y)); // R7
    AST_ANY_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (cond_mode == MODE_ANY && !cond_taken) |-> (flag_x != cond_ref_x && flag_y != cond_ref_y)); // R7
    AST_BOOL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, bool_sel} < (SEL_W+1)'(NUM_BOOL) && !bool_vec[bool_sel] && !bool_invert)
        |-> !bool_taken); // R8

endmodule

// File: tb/shader_cond_unit_test.sv
`timescale 1ns/1ps
module shader_cond_unit_test;

    localparam logic [31:0] P_ONE  = 32'h3F80_0000;
    localparam logic [31:0] P_TWO  = 32'h4000_0000;
    localparam logic [31:0] N_ONE  = 32'hBF80_0000;
    localparam logic [31:0] N_TWO  = 32'hC000_0000;
    localparam logic [31:0] P_ZERO = 32'h0000_0000;
    localparam logic [31:0] N_ZERO = 32'h8000_0000;
    localparam logic [31:0] P_INF  = 32'h7F80_0000;
    localparam logic [31:0] N_INF  = 32'hFF80_0000;
    localparam logic [31:0] QNAN   = 32'h7FC0_0000;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         cmp_valid = 0;
    logic [127:0] cmp_src_a = '0, cmp_src_b = '0;
    logic [2:0]   cmp_op_x = '0, cmp_op_y = '0;
    logic         flag_x, flag_y;
    logic         cond_ref_x = 0, cond_ref_y = 0;
    logic [1:0]   cond_mode = '0;
    logic         cond_taken;
    logic [15:0]  bool_vec = '0;
    logic [3:0]   bool_sel = '0;
    logic         bool_invert = 0;
    logic         bool_taken;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        int         kind;   // 0 flags, 1 condition, 2 uniform
        logic [1:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    shader_cond_unit uut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
        .cmp_src_a(cmp_src_a), .cmp_src_b(cmp_src_b),
        .cmp_op_x(cmp_op_x), .cmp_op_y(cmp_op_y),
        .flag_x(flag_x), .flag_y(flag_y),
        .cond_ref_x(cond_ref_x), .cond_ref_y(cond_ref_y),
        .cond_mode(cond_mode), .cond_taken(cond_taken),
        .bool_vec(bool_vec), .bool_sel(bool_sel),
        .bool_invert(bool_invert), .bool_taken(bool_taken)
    );

    // Monitor: pop one expected item per falling edge and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                logic [1:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = {flag_x, flag_y};
                    1:       act = {1'b0, cond_taken};
                    default: act = {1'b0, bool_taken};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %b expected %b", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic compare(input logic [31:0] ax, input logic [31:0] bx, input logic [2:0] opx,
                           input logic [31:0] ay, input logic [31:0] by, input logic [2:0] opy,
                           input logic ex, input logic ey, input string req);
        @(posedge clk); #1;
        cmp_src_a = {32'h7FC0_0001, 32'hFF80_0000, ay, ax};
        cmp_src_b = {32'h3F80_0000, 32'h0000_0000, by, bx};
        cmp_op_x = opx; cmp_op_y = opy; cmp_valid = 1;
        @(posedge clk); #1;
        cmp_valid = 0;
        sb.push_back('{0, {ex, ey}, req});
    endtask

    task automatic cond(input logic [1:0] m, input logic rx, input logic ry,
                        input logic e, input string req);
        @(posedge clk); #1;
        cond_mode = m; cond_ref_x = rx; cond_ref_y = ry;
        sb.push_back('{1, {1'b0, e}, req});
    endtask

    task automatic uni(input logic [3:0] s, input logic inv, input logic e, input string req);
        @(posedge clk); #1;
        bool_sel = s; bool_invert = inv;
        sb.push_back('{2, {1'b0, e}, req});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        sb.push_back('{0, 2'b00, "R1 reset flags"});

        compare(P_ONE, P_ONE, 3'd0, P_ONE, P_TWO, 3'd2, 1, 1, "R2 eq/lt");
        compare(P_ONE, P_TWO, 3'd1, P_TWO, P_TWO, 3'd3, 1, 1, "R2 ne/le");
        compare(P_TWO, P_ONE, 3'd4, N_ONE, P_ONE, 3'd5, 1, 0, "R2 gt/ge");
        compare(P_ZERO, N_ZERO, 3'd0, N_TWO, N_ONE, 3'd2, 1, 1, "R4 zeros/negatives");
        compare(N_INF, P_INF, 3'd2, P_INF, P_TWO, 3'd3, 1, 0, "R4 infinities");
        compare(QNAN, P_ONE, 3'd1, QNAN, QNAN, 3'd5, 1, 0, "R3 nan ne/ge");
        compare(QNAN, QNAN, 3'd0, P_ONE, QNAN, 3'd4, 0, 0, "R3 nan eq/gt");
        compare(P_ONE, QNAN, 3'd3, QNAN, P_ONE, 3'd2, 0, 0, "R3 nan le/lt");
        compare(P_ONE, P_ONE, 3'd6, P_ONE, P_TWO, 3'd7, 0, 0, "R5 undefined codes");

        // R6: strobe sets (1,1), then the inputs move while the strobe stays low.
        compare(P_ONE, P_ONE, 3'd0, P_TWO, P_TWO, 3'd3, 1, 1, "R6 load before hold");
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            cmp_src_a = {4{QNAN}}; cmp_src_b = {4{N_INF}};
            cmp_op_x = 3'(k); cmp_op_y = 3'(k + 2);
            sb.push_back('{0, 2'b11, "R6 hold without strobe"});
        end

        // Set flags X=1, Y=0 for condition checks.
        compare(P_ONE, P_ONE, 3'd0, P_ONE, P_TWO, 3'd0, 1, 0, "R2 setup for R7");
        cond(2'd0, 1, 1, 1, "R7 any one passes");
        cond(2'd0, 0, 1, 0, "R7 any none pass");
        cond(2'd1, 1, 0, 1, "R7 both pass");
        cond(2'd1, 1, 1, 0, "R7 both one fails");
        cond(2'd2, 1, 0, 1, "R7 x only pass");
        cond(2'd2, 0, 0, 0, "R7 x only ignores y");
        cond(2'd3, 1, 0, 1, "R7 y only pass");
        cond(2'd3, 0, 1, 0, "R7 y only ignores x");

        @(posedge clk); #1 bool_vec = 16'h8005;
        uni(4'd0, 0, 1, "R8 set bit");
        uni(4'd1, 0, 0, "R8 clear bit");
        uni(4'd2, 1, 0, "R8 set bit inverted");
        uni(4'd1, 1, 1, "R8 clear bit inverted");
        uni(4'd15, 0, 1, "R8 top bit");

        @(posedge clk); @(posedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule